// File: doc/BRIEF.md
# Lazy Register Window Controller

This block gives a processor the illusion of an unbounded stack of register windows while holding only two physical register banks. The window in use always sits in one bank. The other bank holds the caller's window, or is being loaded with it. Calls and returns swap the roles of the two banks. Every window deeper than that lives in a memory stack of fixed-size frames.

Traffic to that stack is lazy. Registers move one word at a time, and only in cycles where the pipeline reports that its memory slot is unused. After a call, the caller's modified registers drain to memory behind the callee's execution. After a return, the window two levels down is reloaded into the freed bank in the same background fashion. The processor sees a stall in two cases only: when it calls before the other bank has finished draining, and when it returns into a window that is not yet fully reloaded.

Top module: `regwin_ctrl`

## Requirements
- R1: `rd_data` shows, in the same cycle, the register of the current window chosen by `rd_idx`. A write with `wr_en` updates the register at `wr_idx` in the current window only.
- R2: An accepted call moves execution to the other bank. An accepted return moves it back. A caller whose bank still holds its window is readable at once after the return, with no stall.
- R3: A memory request (`mem_req`=1) is raised only in a cycle with `idle_slot`=1. Each request carries exactly one word.
- R4: A spill writes only the registers written since the window became resident, in ascending index order, with `mem_we`=1. The write address is frame base + index. The frame base is 16 × (number of windows already held in memory), and the first frame starts at address 0. A window with no such registers completes its spill without any store.
- R5: While the other bank is being spilled or filled, a held call raises `stall` and is not taken. It is taken once the transfer is complete.
- R6: A return that leaves the depth at 2 or more starts a fill of the window below into the freed bank. The fill reads all 16 words of that window's frame in ascending index order, with `mem_we`=0. After it, the window's registers equal the memory contents, not the stale bank contents.
- R7: A return while the caller's bank is still being filled raises `stall` and is held off until every register has been reloaded.
- R8: A return at depth 1 is ignored. It raises no stall, produces no memory traffic and leaves the current window's registers unchanged.
- R9: After reset the depth is 1, the other bank is empty, `stall`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Read register index in current window |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Call strobe, held while stalled |
| ret_req | input | 1 | Return strobe, held while stalled |
| idle_slot | input | 1 | Pipeline leaves the memory slot unused this cycle |
| stall | output | 1 | Call or return cannot be taken this cycle |
| mem_req | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | 1 = store (spill), 0 = load (fill) |
| mem_addr | output | 16 | Word address in the window stack |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid in the request cycle |

## Verification
Three windows are nested, and each writes a scattered set of registers. The spill log shows that clean registers are skipped, that stores run in ascending order, and that each window lands in its own frame. Holding `idle_slot` low while work is pending separates background transfer from transfer that ignores the pipeline. Returning into a saved caller, and then into a bank that is still filling, separates the instant resume from the stalled one. A register whose stale bank value differs from memory shows that the fill really reloads it. Finally, an underflow return and a call over a window with nothing dirty show that no-op events produce neither traffic nor stalls.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    // role of the bank that is not executing
    typedef enum logic [1:0] {
        OB_EMPTY = 2'd0,   // holds no live window
        OB_SPILL = 2'd1,   // caller resident, dirty words draining to memory
        OB_SAVED = 2'd2,   // caller resident and identical to top frame
        OB_FILL  = 2'd3    // caller being reloaded from top frame
    } obank_e;

    typedef struct packed {
        logic store;   // spill word moves this cycle
        logic load;    // fill word moves this cycle
        logic done;    // spill found nothing left to store
    } xfer_evt_t;

    function automatic logic other_busy(input obank_e s);
        return (s == OB_SPILL) || (s == OB_FILL);
    endfunction

endpackage

// File: rtl/regwin_bank.sv
module regwin_bank #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [DW-1:0]   wdata,
    input  logic            ld,
    input  logic [IW-1:0]   lidx,
    input  logic [DW-1:0]   ldata,
    input  logic            clr_one,
    input  logic [IW-1:0]   cidx,
    input  logic            clr_all,
    input  logic [IW-1:0]   ridx_a,
    output logic [DW-1:0]   rdata_a,
    input  logic [IW-1:0]   ridx_b,
    output logic [DW-1:0]   rdata_b,
    output logic [NREG-1:0] dirty
);
    logic [DW-1:0] rf [NREG];

    always_ff @(posedge clk) begin
        if (we) rf[widx] <= wdata;
        if (ld) rf[lidx] <= ldata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            dirty <= '0;
        end else begin
            if (clr_one) dirty[cidx] <= 1'b0;
            if (we)      dirty[widx] <= 1'b1;
        end
    end

    assign rdata_a = rf[ridx_a];
    assign rdata_b = rf[ridx_b];

endmodule

// File: rtl/regwin_xfer.sv
module regwin_xfer
    import regwin_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int AW   = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  obank_e          ostate,
    input  logic            idle,
    input  logic            hold,
    input  logic [NREG-1:0] dirty,
    input  logic [IW-1:0]   fptr,
    input  logic [AW-1:0]   sp,
    input  logic [DW-1:0]   spill_data,
    output logic [IW-1:0]   store_idx,
    output xfer_evt_t       evt,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata
);
    localparam logic [AW-1:0] FRAME = AW'(NREG);

    logic any_dirty;

    // lowest pending index wins, so stores go in ascending order
    always_comb begin
        store_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (dirty[i]) store_idx = IW'(i);
        end
    end

    assign any_dirty = |dirty;

    always_comb begin
        evt.store = !hold && idle && (ostate == OB_SPILL) && any_dirty;
        evt.load  = !hold && idle && (ostate == OB_FILL);
        evt.done  = !hold && (ostate == OB_SPILL) && !any_dirty;
    end

    assign mem_req   = evt.store || evt.load;
    assign mem_we    = evt.store;
    assign mem_addr  = evt.store ? (sp + AW'(store_idx))
                                 : (sp - FRAME + AW'(fptr));
    assign mem_wdata = spill_data;

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int AW   = 16,
    parameter int DEPW = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          idle_slot,
    output logic          stall,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [AW-1:0] FRAME = AW'(NREG);

    logic            cur;
    logic            oth;
    obank_e          ostate;
    logic [DEPW-1:0] depth;
    logic [AW-1:0]   sp;
    logic [IW-1:0]   fptr;

    logic            take_call, take_ret, ret_live;
    logic [IW-1:0]   store_idx;
    xfer_evt_t       evt;

    logic [DW-1:0]   rdata_a [2];
    logic [DW-1:0]   rdata_b [2];
    logic [NREG-1:0] dirty_v [2];

    assign oth       = ~cur;
    assign ret_live  = ret_req && !call_req && (depth > DEPW'(1));
    assign take_call = call_req && !other_busy(ostate);
    assign take_ret  = ret_live && (ostate != OB_FILL);
    assign stall     = (call_req && other_busy(ostate))
                     || (ret_live && (ostate == OB_FILL));

    for (genvar b = 0; b < 2; b++) begin : g_bank
        regwin_bank #(.NREG(NREG), .DW(DW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (wr_en && (cur == 1'(b))),
            .widx    (wr_idx),
            .wdata   (wr_data),
            .ld      (evt.load && (oth == 1'(b))),
            .lidx    (fptr),
            .ldata   (mem_rdata),
            .clr_one (evt.store && (oth == 1'(b))),
            .cidx    (store_idx),
            .clr_all ((take_call && (oth == 1'(b))) || (take_ret && (cur == 1'(b)))),
            .ridx_a  (rd_idx),
            .rdata_a (rdata_a[b]),
            .ridx_b  (store_idx),
            .rdata_b (rdata_b[b]),
            .dirty   (dirty_v[b])
        );
    end

    assign rd_data = rdata_a[cur];

    regwin_xfer #(.NREG(NREG), .DW(DW), .AW(AW)) u_xfer (
        .ostate     (ostate),
        .idle       (idle_slot),
        .hold       (take_ret),
        .dirty      (dirty_v[oth]),
        .fptr       (fptr),
        .sp         (sp),
        .spill_data (rdata_b[oth]),
        .store_idx  (store_idx),
        .evt        (evt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= 1'b0;
            ostate <= OB_EMPTY;
            depth  <= DEPW'(1);
            sp     <= '0;
            fptr   <= '0;
        end else if (take_call) begin
            cur    <= oth;
            ostate <= OB_SPILL;
            depth  <= depth + DEPW'(1);
        end else if (take_ret) begin
            cur   <= oth;
            depth <= depth - DEPW'(1);
            if (ostate == OB_SAVED) sp <= sp - FRAME;
            if (depth > DEPW'(2)) begin
                ostate <= OB_FILL;
                fptr   <= '0;
            end else begin
                ostate <= OB_EMPTY;
            end
        end else begin
            if (evt.done) begin
                ostate <= OB_SAVED;
                sp     <= sp + FRAME;
            end
            if (evt.load) begin
                fptr <= fptr + IW'(1);
                if (fptr == IW'(NREG - 1)) ostate <= OB_SAVED;
            end
        end
    end

endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk
    import regwin_pkg::*;
#(
    parameter int DEPW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            call_req,
    input logic            stall,
    input logic            idle_slot,
    input logic            mem_req,
    input logic            mem_we,
    input logic            cur,
    input obank_e          ostate,
    input logic [DEPW-1:0] depth
);
    a_r3_req_in_idle: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> idle_slot);

    a_r5_stall_keeps_bank: assert property (@(posedge clk) disable iff (rst)
        stall |=> (cur == $past(cur)));

    a_r2_call_switches: assert property (@(posedge clk) disable iff (rst)
        (call_req && !stall) |=> (cur != $past(cur)));

    a_r4_spill_is_store: assert property (@(posedge clk) disable iff (rst)
        (mem_req && ostate == OB_SPILL) |-> mem_we);

    a_r6_fill_is_load: assert property (@(posedge clk) disable iff (rst)
        (mem_req && ostate == OB_FILL) |-> !mem_we);

    a_r8_depth_floor: assert property (@(posedge clk) disable iff (rst)
        depth != '0);

endmodule

bind regwin_ctrl regwin_ctrl_chk #(.DEPW(DEPW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .call_req  (call_req),
    .stall     (stall),
    .idle_slot (idle_slot),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .cur       (cur),
    .ostate    (ostate),
    .depth     (depth)
);

// File: tb/tb_regwin_ctrl.sv
module tb_regwin_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        call_req = 1'b0;
    logic        ret_req = 1'b0;
    logic        idle_slot = 1'b0;
    logic        stall;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [256];
    logic        lg_we   [128];
    logic [15:0] lg_addr [128];
    logic [31:0] lg_data [128];
    int          lg_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_ctrl dut (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_req(call_req), .ret_req(ret_req), .idle_slot(idle_slot),
        .stall(stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst && mem_req && lg_n < 128) begin
            lg_we[lg_n]   = mem_we;
            lg_addr[lg_n] = mem_addr;
            lg_data[lg_n] = mem_wdata;
            lg_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        tick(); wr_en = 1'b1; wr_idx = idx; wr_data = d;
        tick(); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] idx, input logic [31:0] exp, input string req);
        rd_idx = idx;
        @(negedge clk);
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic pulse_call();
        tick(); call_req = 1'b1;
        tick(); call_req = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // R9: state right after reset
    task automatic t_reset();
        rst = 1'b1;
        wait_cycles(3);
        rst = 1'b0;
        @(negedge clk);
        check(stall == 1'b0, "R9 stall after reset", 32'(stall), 32'd0);
        check(mem_req == 1'b0, "R9 no request after reset", 32'(mem_req), 32'd0);
    endtask

    // R1 R3 R4: caller's dirty words drain only in idle slots, ascending
    task automatic t_spill();
        int base;
        idle_slot = 1'b0;
        wr(4'd9, 32'hA000_0009);
        wr(4'd2, 32'hA000_0002);
        wr(4'd5, 32'hA000_0005);
        rd_chk(4'd5, 32'hA000_0005, "R1 read back current window");
        base = lg_n;
        pulse_call();
        wait_cycles(5);
        check(lg_n == base, "R3 no transfer without idle slot", 32'(lg_n - base), 32'd0);
        wr(4'd2, 32'hB000_0002);
        rd_chk(4'd2, 32'hB000_0002, "R1 callee write isolated");
        idle_slot = 1'b1;
        wait_cycles(8);
        check(lg_n - base == 3, "R4 spill count", 32'(lg_n - base), 32'd3);
        check(lg_we[base] && lg_addr[base] == 16'd2 && lg_data[base] == 32'hA000_0002,
              "R4 first store", {16'd0, lg_addr[base]}, 32'd2);
        check(lg_we[base+1] && lg_addr[base+1] == 16'd5 && lg_data[base+1] == 32'hA000_0005,
              "R4 second store", {16'd0, lg_addr[base+1]}, 32'd5);
        check(lg_we[base+2] && lg_addr[base+2] == 16'd9 && lg_data[base+2] == 32'hA000_0009,
              "R4 third store", {16'd0, lg_addr[base+2]}, 32'd9);
        check(mem[9] == 32'hA000_0009, "R4 memory content", mem[9], 32'hA000_0009);
    endtask

    // R5 R4: call blocked while spill pending; second frame base is 16
    task automatic t_call_block();
        int base;
        idle_slot = 1'b0;
        wr(4'd3, 32'hB000_0003);
        wr(4'd1, 32'hB000_0001);
        base = lg_n;
        pulse_call();
        wr(4'd0, 32'hC000_0000);
        tick(); call_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(stall == 1'b1, "R5 call stalls during spill", 32'(stall), 32'd1);
        end
        tick(); call_req = 1'b0;
        idle_slot = 1'b1;
        wait_cycles(8);
        check(lg_n - base == 3, "R4 second window spill count", 32'(lg_n - base), 32'd3);
        for (int i = 0; i < 3; i++) begin
            check(lg_we[base+i] && lg_addr[base+i] == 16'(17 + i),
                  "R4 second frame address", {16'd0, lg_addr[base+i]}, 32'(17 + i));
        end
        idle_slot = 1'b0;
    endtask

    // R2 R6 R7: instant resume, then stalled return until fill done
    task automatic t_return();
        int base, n;
        bit ok;
        tick(); ret_req = 1'b1;
        @(negedge clk);
        check(stall == 1'b0, "R2 return to saved caller no stall", 32'(stall), 32'd0);
        tick(); ret_req = 1'b0;
        rd_chk(4'd1, 32'hB000_0001, "R2 caller r1 resumed");
        rd_chk(4'd2, 32'hB000_0002, "R2 caller r2 resumed");
        rd_chk(4'd3, 32'hB000_0003, "R2 caller r3 resumed");
        base = lg_n;
        tick(); ret_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(stall == 1'b1, "R7 return stalls during fill", 32'(stall), 32'd1);
        end
        idle_slot = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (stall && n < 100);
        tick(); ret_req = 1'b0;
        check(lg_n - base == 16, "R6 fill word count", 32'(lg_n - base), 32'd16);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (lg_we[base+i] || lg_addr[base+i] != 16'(i)) ok = 1'b0;
        end
        check(ok, "R6 fill ascending loads from frame 0", 32'(ok), 32'd1);
        rd_chk(4'd2, 32'hA000_0002, "R6 restored r2");
        rd_chk(4'd5, 32'hA000_0005, "R6 restored r5");
        rd_chk(4'd9, 32'hA000_0009, "R6 restored r9");
        rd_chk(4'd0, 32'h0000_0000, "R6 stale bank word replaced");
    endtask

    // R8: return at depth 1 is a no-op
    task automatic t_underflow();
        int base;
        base = lg_n;
        tick(); ret_req = 1'b1;
        @(negedge clk);
        check(stall == 1'b0, "R8 underflow return no stall", 32'(stall), 32'd0);
        tick(); ret_req = 1'b0;
        wait_cycles(4);
        check(lg_n == base, "R8 underflow no traffic", 32'(lg_n - base), 32'd0);
        rd_chk(4'd2, 32'hA000_0002, "R8 window unchanged");
    endtask

    // R4 R5: clean window spills with no stores, next call not stalled
    task automatic t_clean();
        int base;
        base = lg_n;
        idle_slot = 1'b1;
        pulse_call();
        wait_cycles(4);
        check(lg_n == base, "R4 clean window no stores", 32'(lg_n - base), 32'd0);
        tick(); call_req = 1'b1;
        @(negedge clk);
        check(stall == 1'b0, "R5 call taken after empty spill", 32'(stall), 32'd0);
        tick(); call_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_spill();
        t_call_block();
        t_return();
        t_underflow();
        t_clean();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule